// File: doc/BRIEF.md
# Nonvolatile Wiper Position Controller

This block is the digital control section of a 100-tap digitally controlled potentiometer. A host selects the block by pulling an active-low select line. It sets a direction line, and each falling edge of an increment strobe then moves a 7-bit wiper counter one tap up or down. The counter stops at either end and never wraps. The counter is decoded into a one-hot tap select vector that would drive the transfer gates of a resistor array. The resistor array itself is not part of this block.

When the select line goes high again, the level of the strobe decides what happens to the position. If the strobe is high, the position is written into a register that models a nonvolatile cell. The write takes a parameterised number of clock cycles, and a busy flag is raised for that time. If the strobe is low, nothing is written and the new position stays in use only until the next power-up. The power-up reset reloads the wiper from the stored value. A separate first-initialisation reset clears the stored value and the write counter. Once a store has finished, or after a deselect without a store, the block reports standby until it is selected again. A wear flag rises once the number of writes exceeds an endurance limit.

Top module: `wiper_ctrl`

## Requirements
- R1: While rst_n is low, the wiper takes the stored value. After the init_n reset, the stored value is 0, so a power-up then gives position 0.
- R2: While the block is selected, the wiper moves by exactly one tap on the clock edge that first samples step low after it was sampled high. It moves up when dir_up is 1 and down when dir_up is 0.
- R3: Up steps at position NUM_TAPS-1 (99) and down steps at position 0 leave the position unchanged.
- R4: While sel_n is high, falling edges of step do not change the position.
- R5: A sampled rise of sel_n while step is high writes the position to the store. store_busy is then high for exactly STORE_CYCLES cycles, starting on the next edge.
- R6: A sampled rise of sel_n while step is low writes nothing and raises no busy flag. The current position stays in effect until the next power-up, which recalls the older stored value.
- R7: While store_busy is high, the select line and the step strobe are ignored. Steps do not move the wiper, and no further store starts.
- R8: standby is 1 out of reset. It goes to 0 while the block is selected and not busy. It goes to 1 on the edge where a store's busy time ends, or on a deselect that does not store.
- R9: tap_sel has exactly one bit set, and that bit is at index wiper_pos.
- R10: worn_out is 0 while the number of stores since init_n is at most ENDURANCE, and 1 once that number exceeds it.
- R11: The direction may change while the block stays selected, and later steps follow the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low power-up reset; recalls the stored position |
| init_n | input | 1 | Synchronous active-low first initialisation of the store and write count |
| sel_n | input | 1 | Active-low select |
| dir_up | input | 1 | Step direction, 1 = up |
| step | input | 1 | Increment strobe, acts on its falling edge |
| wiper_pos | output | 7 | Binary wiper position |
| tap_sel | output | 100 | One-hot tap select |
| store_busy | output | 1 | Store write in progress |
| standby | output | 1 | Low-power standby indicator |
| worn_out | output | 1 | Write endurance limit exceeded |

## Verification
The bench drives the wiper past both ends. A counter that wraps would jump from 99 to 0 or from 0 to 99 instead of staying put. It deselects with the strobe at each level. A design that ignores the strobe level would either store the position after a no-store deselect, which shows up when a later power-up recalls the wrong value, or miss the busy window after a store-type deselect. The bench also toggles the select and the strobe during a busy window. A design that still listens then would move the wiper or lengthen the busy time. The write count is taken exactly to the endurance limit and one write past it, which catches an off-by-one in the wear flag.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    // control-edge tracking state of the top level
    typedef struct packed {
        logic step_p;   // step as sampled on the previous edge
        logic sel_p;    // sel_n as sampled on the previous edge
        logic standby;  // low-power indicator
    } ctl_state_t;
endpackage

// File: rtl/wiper_counter.sv
module wiper_counter #(
    parameter int NUM_TAPS = 100,
    parameter int POS_W    = $clog2(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] recall_val,
    input  logic             adv,
    input  logic             up,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] TOP = POS_W'(NUM_TAPS - 1);

    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (!rst_n) begin
            pos_d = recall_val;
        end else if (adv) begin
            if (up && pos_q != TOP)
                pos_d = pos_q + 1'b1;
            else if (!up && pos_q != '0)
                pos_d = pos_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end

    assign pos = pos_q;

    // R2: one tap per accepted up step
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && up && pos_q != TOP) |=> (pos_q == $past(pos_q) + 1'b1));
    // R3: no wrap at the top end
    p_no_wrap_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && up && pos_q == TOP) |=> (pos_q == TOP));
    // R3: no wrap at the bottom end
    p_no_wrap_bot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !up && pos_q == '0) |=> (pos_q == '0));
endmodule

// File: rtl/nv_store.sv
module nv_store #(
    parameter int POS_W        = 7,
    parameter int STORE_CYCLES = 20000,
    parameter int ENDURANCE    = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_n,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wr_val,
    output logic [POS_W-1:0] nv_val,
    output logic             busy,
    output logic             done,
    output logic             worn
);
    localparam int CW = $clog2(STORE_CYCLES + 1);
    localparam int WW = $clog2(ENDURANCE + 2);
    localparam logic [WW-1:0] WSAT = WW'(ENDURANCE + 1);

    typedef struct packed {
        logic [POS_W-1:0] val;
        logic [CW-1:0]    cnt;
        logic [WW-1:0]    wcount;
    } nv_state_t;

    nv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
        if (!rst_n)
            st_d.cnt = '0;
        if (wr_en) begin
            st_d.val = wr_val;
            st_d.cnt = CW'(STORE_CYCLES);
            if (st_q.wcount != WSAT)
                st_d.wcount = st_q.wcount + 1'b1;
        end
        if (!init_n) begin
            st_d.val    = '0;
            st_d.wcount = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign nv_val = st_q.val;
    assign busy   = (st_q.cnt != '0);
    assign done   = (st_q.cnt == CW'(1));
    assign worn   = (st_q.wcount > WW'(ENDURANCE));

    // R6: the stored value moves only on a write
    p_store_only_on_write_r6: assert property (@(posedge clk) disable iff (!init_n)
        !wr_en |=> $stable(st_q.val));
    // R7: busy holds until its final cycle
    p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R7: no write is accepted during busy
    p_no_write_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en);
    // R10: wear flag is sticky until first initialisation
    p_worn_sticky_r10: assert property (@(posedge clk) disable iff (!init_n)
        worn |=> worn);
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
    parameter int NUM_TAPS = 100,
    parameter int POS_W    = $clog2(NUM_TAPS)
) (
    input  logic [POS_W-1:0]    pos,
    output logic [NUM_TAPS-1:0] taps
);
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign taps[i] = (pos == POS_W'(i));
    end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
    parameter int NUM_TAPS     = 100,
    parameter int STORE_CYCLES = 20000,
    parameter int ENDURANCE    = 100000,
    localparam int POS_W       = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_n,
    input  logic                sel_n,
    input  logic                dir_up,
    input  logic                step,
    output logic [POS_W-1:0]    wiper_pos,
    output logic [NUM_TAPS-1:0] tap_sel,
    output logic                store_busy,
    output logic                standby,
    output logic                worn_out
);
    import wiper_pkg::*;

    ctl_state_t       ctl_d, ctl_q;
    logic [POS_W-1:0] nv_val;
    logic             st_done;
    logic             sel_act, step_fall, sel_rise, adv, wr_en;

    always_comb begin
        sel_act   = !sel_n && !store_busy;
        step_fall = ctl_q.step_p && !step;
        sel_rise  = sel_n && !ctl_q.sel_p && !store_busy;
        adv       = rst_n && sel_act && step_fall;
        wr_en     = rst_n && sel_rise && step;

        ctl_d        = ctl_q;
        ctl_d.step_p = step;
        ctl_d.sel_p  = sel_n;
        if (sel_act)
            ctl_d.standby = 1'b0;
        else if (st_done || (sel_rise && !step))
            ctl_d.standby = 1'b1;
        if (!rst_n) begin
            ctl_d.step_p  = 1'b1;
            ctl_d.sel_p   = 1'b1;
            ctl_d.standby = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    wiper_counter #(.NUM_TAPS(NUM_TAPS), .POS_W(POS_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .recall_val (nv_val),
        .adv        (adv),
        .up         (dir_up),
        .pos        (wiper_pos)
    );

    nv_store #(.POS_W(POS_W), .STORE_CYCLES(STORE_CYCLES), .ENDURANCE(ENDURANCE)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_n (init_n),
        .wr_en  (wr_en),
        .wr_val (wiper_pos),
        .nv_val (nv_val),
        .busy   (store_busy),
        .done   (st_done),
        .worn   (worn_out)
    );

    tap_decoder #(.NUM_TAPS(NUM_TAPS), .POS_W(POS_W)) u_dec (
        .pos  (wiper_pos),
        .taps (tap_sel)
    );

    assign standby = ctl_q.standby;

    // R4: deselected means the wiper holds
    p_deselect_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> $stable(wiper_pos));
    // R5: a store-type deselect starts the busy window
    p_store_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !ctl_q.sel_p && !store_busy && step) |=> store_busy);
    // R9: exactly one tap, at the wiper position
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(tap_sel) && tap_sel[wiper_pos]);
    // R8: selected and idle means not in standby
    p_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !store_busy) |=> !standby);
endmodule

// File: tb/wiper_ctrl_tb.sv
module wiper_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS  = 100;
    localparam int STC   = 5;
    localparam int ENDUR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0, init_n = 1'b0, sel_n = 1'b1, dir_up = 1'b1, step = 1'b1;
    logic [6:0]      wiper_pos;
    logic [TAPS-1:0] tap_sel;
    logic store_busy, standby, worn_out;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_ctrl #(.NUM_TAPS(TAPS), .STORE_CYCLES(STC), .ENDURANCE(ENDUR)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .sel_n(sel_n), .dir_up(dir_up),
        .step(step), .wiper_pos(wiper_pos), .tap_sel(tap_sel),
        .store_busy(store_busy), .standby(standby), .worn_out(worn_out)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_tap(int exp);
        chk("R9 count", $countones(tap_sel), 1);
        chk("R9 index", int'(tap_sel[exp]), 1);
    endtask

    task automatic pulse(bit up, int n);
        for (int i = 0; i < n; i++) begin
            dir_up = up;
            step = 1'b0; @(negedge clk);
            step = 1'b1; @(negedge clk);
        end
    endtask

    task automatic power_up();
        rst_n = 1'b0; repeat (2) @(negedge clk);
        rst_n = 1'b1; @(negedge clk);
    endtask

    // deselect with step high, return measured busy length
    task automatic deselect_store(output int blen);
        blen = 0;
        step = 1'b1; sel_n = 1'b1; @(negedge clk);
        for (int i = 0; i < 4*STC; i++) begin
            if (store_busy) blen++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        init_n = 1'b0; rst_n = 1'b0; repeat (3) @(negedge clk);
        init_n = 1'b1; rst_n = 1'b1; @(negedge clk);
        chk("R1 init pos", wiper_pos, 0);
        chk_tap(0);
        chk("R8 reset standby", standby, 1);
        chk("R5 reset busy", store_busy, 0);
        chk("R10 reset worn", worn_out, 0);
    endtask

    task automatic t_move();
        sel_n = 1'b0; @(negedge clk);
        chk("R8 selected", standby, 0);
        pulse(1, 5);
        chk("R2 up 5", wiper_pos, 5);
        chk_tap(5);
        pulse(0, 2);
        chk("R11 dir change", wiper_pos, 3);
    endtask

    task automatic t_store();
        int blen;
        deselect_store(blen);
        chk("R5 busy length", blen, STC);
        chk("R8 standby after store", standby, 1);
    endtask

    task automatic t_nostore();
        sel_n = 1'b0; @(negedge clk);
        pulse(1, 1);
        dir_up = 1'b1; step = 1'b0; @(negedge clk);
        chk("R2 held-low step", wiper_pos, 5);
        sel_n = 1'b1; @(negedge clk); @(negedge clk);
        chk("R6 no busy", store_busy, 0);
        chk("R8 standby no store", standby, 1);
        chk("R6 position kept", wiper_pos, 5);
        step = 1'b1; @(negedge clk);
        power_up();
        chk("R6 recall older", wiper_pos, 3);
    endtask

    task automatic t_deselected();
        sel_n = 1'b1;
        pulse(1, 3);
        chk("R4 deselected steps", wiper_pos, 3);
    endtask

    task automatic t_ends();
        sel_n = 1'b0; @(negedge clk);
        pulse(0, 5);
        chk("R3 bottom", wiper_pos, 0);
        chk_tap(0);
        pulse(1, 105);
        chk("R3 top", wiper_pos, 99);
        chk_tap(99);
        pulse(0, 1);
        chk("R3 off top", wiper_pos, 98);
        pulse(1, 1);
    endtask

    task automatic t_busy_ignore();
        int blen = 0;
        step = 1'b1; sel_n = 1'b1; @(negedge clk);
        if (store_busy) blen++;
        sel_n = 1'b0; @(negedge clk);
        if (store_busy) blen++;
        dir_up = 1'b0; step = 1'b0; @(negedge clk);
        if (store_busy) blen++;
        step = 1'b1; @(negedge clk);
        if (store_busy) blen++;
        sel_n = 1'b1; @(negedge clk);
        for (int i = 0; i < 4*STC; i++) begin
            if (store_busy) blen++;
            @(negedge clk);
        end
        chk("R7 step ignored", wiper_pos, 99);
        chk("R7 busy length", blen, STC);
        power_up();
        chk("R5 stored 99", wiper_pos, 99);
    endtask

    task automatic t_wear();
        int blen;
        sel_n = 1'b0; @(negedge clk);
        deselect_store(blen);
        chk("R10 at limit", worn_out, 0);
        sel_n = 1'b0; @(negedge clk);
        deselect_store(blen);
        chk("R10 past limit", worn_out, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_move();
        t_store();
        t_nostore();
        t_deselected();
        t_ends();
        t_busy_ignore();
        t_wear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule